// File: doc/BRIEF.md
# Smart card clock and ETU generator

This block turns a fast master clock into the clock driven to a smart card and into elementary time unit (ETU) timing for the serial character engine. A programmable prescaler divides the master clock. A fixed halving stage after it gives the card clock a 50 % duty cycle. A one-cycle enable pulse marks every rising card clock edge, so logic in the master clock domain can count card clocks without crossing domains.

An ETU counter counts those card clock pulses. Its divisor comes from a byte that holds a clock-rate index in the upper nibble and a baud-adjust index in the lower nibble. Both indices are decoded, and the divisor is the integer quotient of the clock-rate factor by the baud-adjust factor, read from a lookup built at elaboration. A direct divisor override can replace the decoded value. The counter pulses a bit-edge strobe at every ETU boundary and a sample strobe at mid-ETU. A sync pulse restarts the count so that bit timing lines up with a received start edge.

Top module: `sc_etu_clkgen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `card_clk_o`, `cclk_tick_o`, `etu_edge_o` and `etu_ctr_o` are all low.
- R2: With `presc_i` = N, the card clock period is 2·N master cycles, and a value of 0 acts as N = 1 (period 2). With the default value 13 and a 96 MHz master clock, this gives about 3.69 MHz.
- R3: `cclk_tick_o` is high for exactly one master cycle, and only in the first cycle of each card clock high phase.
- R4: While `clk_en_i` is low, from the next cycle on, `card_clk_o` and `cclk_tick_o` stay low, no ETU strobe occurs, and the ETU count holds its value.
- R5: The upper nibble of `fd_i` selects the clock-rate factor F: 0→372, 1→372, 2→558, 3→744, 4→1116, 5→1488, 6→1860, 9→512, 10→768, 11→1024, 12→1536, 13→2048. The reserved codes 7, 8, 14 and 15 give 372.
- R6: The lower nibble of `fd_i` selects the baud-adjust factor D: 1→1, 2→2, 3→4, 4→8, 5→16, 6→32, 7→64, 8→12, 9→20. All other codes give 1.
- R7: The ETU divisor is floor(F/D), clamped to at least 12. When `div_ovr_en_i` is high, `div_ovr_i` is used instead, with the same clamp. A change takes effect one master cycle after it is applied.
- R8: `etu_edge_o` is a one-cycle pulse once every divisor card clocks. It rises in the cycle after the card clock pulse that completes the ETU.
- R9: `etu_ctr_o` pulses floor(divisor/2) card clocks after each edge strobe, and it is never high in the same cycle as `etu_edge_o`.
- R10: A `sync_i` pulse clears the ETU count, and neither strobe fires in the following cycle. The next sample strobe then comes floor(divisor/2) card clocks later, and the next edge strobe comes one divisor later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| presc_i | input | 6 | Prescaler ratio; 0 means 1 |
| fd_i | input | 8 | Clock-rate index [7:4], baud-adjust index [3:0] |
| div_ovr_en_i | input | 1 | Use `div_ovr_i` as the ETU divisor |
| div_ovr_i | input | 12 | Divisor override value |
| sync_i | input | 1 | Restart the ETU count |
| clk_en_i | input | 1 | Card clock enable; low holds the card clock low |
| card_clk_o | output | 1 | Card clock |
| cclk_tick_o | output | 1 | One-cycle pulse at each card clock rising edge |
| etu_edge_o | output | 1 | ETU boundary strobe |
| etu_ctr_o | output | 1 | Mid-ETU sample strobe |

## Verification
The assertions check these relations on every cycle:
- the clock pulse marks exactly the rising card clock edges;
- a disabled clock stays low and silent;
- the divisor never falls below its floor;
- the two strobes never coincide, and each edge strobe follows a clock pulse;
- a sync pulse suppresses strobes in the next cycle.

Only the bench scenarios can show the numbers: the clock period for each prescaler value, the decoded divisor for each index pair (reserved codes included), the clamp and override cases, the centre offset for odd divisors, and the phase shift that a sync pulse causes.

// File: rtl/sc_etu_pkg.sv
// Package: shared constants and the decode functions for the clock-rate
// and baud-adjust indices. Assumes 4-bit indices and a 12-bit divisor.
package sc_etu_pkg;

    localparam int unsigned ETU_DEFAULT = 372;

    // Clock-rate factor F for a 4-bit index; reserved codes give 372.
    function automatic logic [11:0] f_of(input logic [3:0] code);
        logic [11:0] f;
        case (code)
            4'd2:    f = 12'd558;
            4'd3:    f = 12'd744;
            4'd4:    f = 12'd1116;
            4'd5:    f = 12'd1488;
            4'd6:    f = 12'd1860;
            4'd9:    f = 12'd512;
            4'd10:   f = 12'd768;
            4'd11:   f = 12'd1024;
            4'd12:   f = 12'd1536;
            4'd13:   f = 12'd2048;
            default: f = 12'd372;
        endcase
        return f;
    endfunction

    // Baud-adjust factor D for a 4-bit index; reserved codes give 1.
    function automatic logic [11:0] d_of(input logic [3:0] code);
        logic [11:0] d;
        case (code)
            4'd2:    d = 12'd2;
            4'd3:    d = 12'd4;
            4'd4:    d = 12'd8;
            4'd5:    d = 12'd16;
            4'd6:    d = 12'd32;
            4'd7:    d = 12'd64;
            4'd8:    d = 12'd12;
            4'd9:    d = 12'd20;
            default: d = 12'd1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/sc_clk_prescaler.sv
// Card clock prescaler: divides the master clock by presc_i (0 acts as 1),
// then halves it to give a 50 % duty card clock. tick_o is a registered
// one-cycle pulse that coincides with each rising card clock edge.
// Assumes presc_i may change at any time; the counter recovers through >=.
module sc_clk_prescaler #(
    parameter int PRESC_W = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic               clk_en_i,
    output logic               card_clk_o,
    output logic               tick_o
);

    logic [PRESC_W-1:0] pcnt_q;
    logic [PRESC_W-1:0] limit;
    logic               pre_tick;
    logic               half_q;
    logic               tick_q;

    // Terminal count of the prescaler, treating zero as divide-by-one.
    always_comb begin
        limit    = (presc_i == '0) ? '0 : presc_i - PRESC_W'(1);
        pre_tick = (pcnt_q >= limit);
    end

    // Prescaler counter: wraps on the terminal count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)       pcnt_q <= '0;
        else if (pre_tick) pcnt_q <= '0;
        else               pcnt_q <= pcnt_q + PRESC_W'(1);
    end

    // Halving stage and rising-edge pulse, both forced low when disabled.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            half_q <= 1'b0;
            tick_q <= 1'b0;
        end else if (!clk_en_i) begin
            half_q <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            if (pre_tick) half_q <= ~half_q;
            tick_q <= pre_tick & ~half_q;
        end
    end

    assign card_clk_o = half_q;
    assign tick_o     = tick_q;

endmodule

// File: rtl/sc_fd_divisor.sv
// ETU divisor selection: a lookup of floor(F/D) for every value of the
// index byte, computed at elaboration, or a direct override. The result is
// clamped to MIN_ETU and registered. Assumes F/D never exceeds 2^ETU_W-1.
module sc_fd_divisor #(
    parameter int ETU_W   = 12,
    parameter int MIN_ETU = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [7:0]       fd_i,
    input  logic             ovr_en_i,
    input  logic [ETU_W-1:0] ovr_i,
    output logic [ETU_W-1:0] div_o
);

    localparam int          LUT_N = 256;
    localparam logic [ETU_W-1:0] FLOOR_V = ETU_W'(MIN_ETU);
    localparam logic [ETU_W-1:0] RESET_V = ETU_W'(sc_etu_pkg::ETU_DEFAULT);

    logic [ETU_W-1:0] lut [LUT_N];
    logic [ETU_W-1:0] raw;
    logic [ETU_W-1:0] clamped;
    logic [ETU_W-1:0] div_q;

    // One constant entry per index byte: clamped quotient of F by D.
    for (genvar g = 0; g < LUT_N; g++) begin : g_lut
        localparam int unsigned FV = int'(sc_etu_pkg::f_of(4'(g / 16)));
        localparam int unsigned DV = int'(sc_etu_pkg::d_of(4'(g % 16)));
        localparam int unsigned QV = FV / DV;
        localparam int unsigned CV = (QV < MIN_ETU) ? MIN_ETU : QV;
        assign lut[g] = ETU_W'(CV);
    end

    // Pick the override or the table value, then apply the floor.
    always_comb begin
        raw     = ovr_en_i ? ovr_i : lut[fd_i];
        clamped = (raw < FLOOR_V) ? FLOOR_V : raw;
    end

    // Register the divisor so the counter compare sees a stable value.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) div_q <= RESET_V;
        else         div_q <= clamped;
    end

    assign div_o = div_q;

endmodule

// File: rtl/sc_etu_counter.sv
// ETU counter: counts card clock pulses and wraps at the divisor, pulsing
// edge_o at each wrap and ctr_o floor(div/2) pulses after it. sync_i
// clears the count and suppresses both strobes. Assumes div_i >= 12.
module sc_etu_counter #(
    parameter int ETU_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             sync_i,
    input  logic [ETU_W-1:0] div_i,
    output logic             edge_o,
    output logic             ctr_o
);

    logic [ETU_W-1:0] cnt_q;
    logic [ETU_W-1:0] last_v;
    logic [ETU_W-1:0] mid_v;
    logic             edge_q;
    logic             ctr_q;

    // Compare points for the wrap and the mid-ETU sample.
    always_comb begin
        last_v = div_i - ETU_W'(1);
        mid_v  = (div_i >> 1) - ETU_W'(1);
    end

    // Count card clock pulses, restart on sync, register the strobes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            edge_q <= 1'b0;
            ctr_q  <= 1'b0;
        end else begin
            edge_q <= 1'b0;
            ctr_q  <= 1'b0;
            if (sync_i) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q >= last_v) begin
                    cnt_q  <= '0;
                    edge_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + ETU_W'(1);
                    ctr_q <= (cnt_q == mid_v);
                end
            end
        end
    end

    assign edge_o = edge_q;
    assign ctr_o  = ctr_q;

endmodule

// File: rtl/sc_etu_clkgen.sv
// Top of the smart card clock and ETU generator: prescaler and halver for
// the card clock, divisor selection, and the ETU strobe counter.
// Assumes a single master clock domain and synchronous active-low reset.
module sc_etu_clkgen #(
    parameter int PRESC_W = 6,
    parameter int ETU_W   = 12,
    parameter int MIN_ETU = 12
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic [7:0]         fd_i,
    input  logic               div_ovr_en_i,
    input  logic [ETU_W-1:0]   div_ovr_i,
    input  logic               sync_i,
    input  logic               clk_en_i,
    output logic               card_clk_o,
    output logic               cclk_tick_o,
    output logic               etu_edge_o,
    output logic               etu_ctr_o
);

    logic             tick;
    logic [ETU_W-1:0] etu_div;

    sc_clk_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .presc_i    (presc_i),
        .clk_en_i   (clk_en_i),
        .card_clk_o (card_clk_o),
        .tick_o     (tick)
    );

    sc_fd_divisor #(.ETU_W(ETU_W), .MIN_ETU(MIN_ETU)) u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .fd_i     (fd_i),
        .ovr_en_i (div_ovr_en_i),
        .ovr_i    (div_ovr_i),
        .div_o    (etu_div)
    );

    sc_etu_counter #(.ETU_W(ETU_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick),
        .sync_i (sync_i),
        .div_i  (etu_div),
        .edge_o (etu_edge_o),
        .ctr_o  (etu_ctr_o)
    );

    assign cclk_tick_o = tick;

endmodule

// File: rtl/sc_etu_clkgen_chk.sv
// Checker for sc_etu_clkgen: cycle relations between the card clock, its
// pulse, the divisor and the ETU strobes. Attached with bind below.
module sc_etu_clkgen_chk #(
    parameter int ETU_W   = 12,
    parameter int MIN_ETU = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sync_i,
    input logic             clk_en_i,
    input logic             card_clk_o,
    input logic             cclk_tick_o,
    input logic             etu_edge_o,
    input logic             etu_ctr_o,
    input logic [ETU_W-1:0] etu_div
);

    AST_TICK_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cclk_tick_o |-> (card_clk_o && !$past(card_clk_o))); // R3
    AST_RISE_HAS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (card_clk_o && !$past(card_clk_o)) |-> cclk_tick_o); // R3
    AST_GATED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clk_en_i |=> (!card_clk_o && !cclk_tick_o)); // R4
    AST_DIV_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        etu_div >= ETU_W'(MIN_ETU)); // R7
    AST_EDGE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        etu_edge_o |-> $past(cclk_tick_o)); // R8
    AST_EDGE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        etu_edge_o |=> !etu_edge_o); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(etu_edge_o && etu_ctr_o)); // R9
    AST_SYNC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_i |=> (!etu_edge_o && !etu_ctr_o)); // R10

endmodule

bind sc_etu_clkgen sc_etu_clkgen_chk #(.ETU_W(ETU_W), .MIN_ETU(MIN_ETU)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .clk_en_i    (clk_en_i),
    .card_clk_o  (card_clk_o),
    .cclk_tick_o (cclk_tick_o),
    .etu_edge_o  (etu_edge_o),
    .etu_ctr_o   (etu_ctr_o),
    .etu_div     (etu_div)
);

// File: tb/tb_sc_etu_clkgen.sv
// Scoreboard bench: driver tasks queue expected ETU periods and centre
// offsets; a monitor pops and compares them as strobes appear.
module tb_sc_etu_clkgen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  presc = 6'd13;
    logic [7:0]  fd = 8'h11;
    logic        ovr_en = 1'b0;
    logic [11:0] ovr = 12'd0;
    logic        sync = 1'b0;
    logic        clk_en = 1'b1;
    logic        card_clk, tick, edge_s, ctr_s;

    sc_etu_clkgen dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .presc_i      (presc),
        .fd_i         (fd),
        .div_ovr_en_i (ovr_en),
        .div_ovr_i    (ovr),
        .sync_i       (sync),
        .clk_en_i     (clk_en),
        .card_clk_o   (card_clk),
        .cclk_tick_o  (tick),
        .etu_edge_o   (edge_s),
        .etu_ctr_o    (ctr_s)
    );

    always #2 clk = ~clk;

    int      n_run = 0;
    int      n_fail = 0;
    longint  cyc = 0;
    bit      done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    typedef struct {
        string  req;
        longint per;
        longint ctr;
    } exp_t;

    exp_t   q[$];
    bit     armed = 1'b0;
    longint last_edge = 0;
    bit     prev_clk = 1'b0;
    int     tick_mism = 0;
    longint last_tick = 0;
    longint tick_gap = 0;
    int     quiet_hits = 0;
    bit     quiet_win = 1'b0;

    // Monitor: compares strobe timing against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (((card_clk && !prev_clk) ? 1'b1 : 1'b0) != tick) tick_mism++;
            if (tick) begin
                tick_gap  = cyc - last_tick;
                last_tick = cyc;
            end
            if (quiet_win && (card_clk || tick || edge_s || ctr_s)) quiet_hits++;
            if (ctr_s && armed && q.size() > 0)
                chk({q[0].req, " centre"}, cyc - last_edge, q[0].ctr);
            if (edge_s) begin
                if (armed && q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.req, cyc - last_edge, e.per);
                end
                last_edge = cyc;
                armed     = 1'b1;
            end
        end
        prev_clk = card_clk;
    end

    // Driver: apply a divisor setting and queue three expected ETU periods.
    task automatic run_div(string req, logic [5:0] p, logic [7:0] f,
                           logic oe, logic [11:0] ov, int div);
        longint pp;
        @(posedge clk); #1;
        presc = p; fd = f; ovr_en = oe; ovr = ov;
        armed = 1'b0;
        q.delete();
        pp = (p == 0) ? 2 : 2 * longint'(p);
        for (int i = 0; i < 3; i++) q.push_back('{req, pp * div, pp * (div / 2)});
        while (q.size() > 0) @(posedge clk);
    endtask

    // Measure the card clock period for a prescaler value.
    task automatic meas_clk(string req, logic [5:0] p, longint exp_per);
        @(posedge clk); #1;
        presc = p;
        repeat (3 * (int'(exp_per) + 2)) @(posedge clk);
        chk(req, tick_gap, exp_per);
    endtask

    longint s_cyc, ctr_at, edge_at;

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: outputs low during reset.
        chk("R1 card_clk in reset", card_clk, 0);
        chk("R1 edge in reset", edge_s | ctr_s | tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", card_clk | tick | edge_s | ctr_s, 0);

        // R2: card clock period per prescaler value (default 13).
        meas_clk("R2 presc 13", 6'd13, 26);
        meas_clk("R2 presc 0", 6'd0, 2);
        meas_clk("R2 presc 5", 6'd5, 10);
        meas_clk("R2 presc 1", 6'd1, 2);

        // R5/R6/R7: decoded divisors with prescaler 1 (2 cycles per clock).
        run_div("R5 F1 D1 372", 6'd1, 8'h11, 1'b0, 12'd0, 372);
        run_div("R5 F3 D1 744", 6'd1, 8'h31, 1'b0, 12'd0, 744);
        run_div("R5 F13 D1 2048", 6'd1, 8'hD1, 1'b0, 12'd0, 2048);
        run_div("R5 F9 D4 64", 6'd1, 8'h94, 1'b0, 12'd0, 64);
        run_div("R6 reserved F7 D15 372", 6'd1, 8'h7F, 1'b0, 12'd0, 372);
        run_div("R6 F1 D8 31 odd", 6'd1, 8'h18, 1'b0, 12'd0, 31);
        run_div("R7 F3 D9 37", 6'd1, 8'h39, 1'b0, 12'd0, 37);
        run_div("R7 clamp F1 D6", 6'd1, 8'h16, 1'b0, 12'd0, 12);
        run_div("R7 override 100", 6'd1, 8'h11, 1'b1, 12'd100, 100);
        run_div("R7 override clamp", 6'd1, 8'h11, 1'b1, 12'd5, 12);
        run_div("R8 presc 3 div 64", 6'd3, 8'h94, 1'b0, 12'd0, 64);

        // R4: disabled clock is silent, then timing resumes.
        run_div("R8 before disable", 6'd1, 8'h94, 1'b0, 12'd0, 64);
        @(posedge clk); #1;
        clk_en = 1'b0;
        @(posedge clk); #1;
        quiet_win = 1'b1;
        repeat (400) @(posedge clk);
        #1;
        quiet_win = 1'b0;
        chk("R4 quiet while disabled", quiet_hits, 0);
        clk_en = 1'b1;
        run_div("R4 resumed", 6'd1, 8'h94, 1'b0, 12'd0, 64);

        // R3: every rising card clock edge carried the pulse.
        chk("R3 tick on rising edge", tick_mism, 0);

        // R10: sync restarts the count mid-ETU.
        armed = 1'b0;
        while (!edge_s) @(negedge clk);
        repeat (40) @(posedge clk);
        #1;
        sync = 1'b1;
        s_cyc = cyc;
        @(posedge clk); #1;
        sync = 1'b0;
        while (!ctr_s) @(negedge clk);
        ctr_at = cyc;
        while (!edge_s) @(negedge clk);
        edge_at = cyc;
        chk("R10 edge-centre after sync", edge_at - ctr_at, 64);
        chk("R10 edge shifted by sync",
            ((edge_at - s_cyc >= 127) && (edge_at - s_cyc <= 131)) ? 1 : 0, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (!done && cyc == 190000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule